// File: doc/BRIEF.md
# Weighted Time-Slot Memory Arbiter

This block lets several on-chip masters share one external static memory port that takes one access per clock. Time is cut into a repeating frame of slots. A table, filled at reset from a parameter, names the master that owns each slot. By default the frame has 83 slots. Master 0, the main processor, owns 65 of them. Master 1, a fast link, owns 11. Masters 2 and 3, the slow peripherals, own 4 and 3. The table gives each master a guaranteed share of the bandwidth. A slot whose owner is not requesting is not wasted: it goes to the next requester in round-robin order.

Each master has a valid/ready request channel carrying a 20-bit word address, a 36-bit write word and a write flag. The request completes in the cycle where valid and ready are both high. While ready is low the master is being held off, and it must keep valid, address, write flag and write data unchanged. Ready depends on valid in the same cycle, and valid must not depend on ready. Read data comes back on a shared 36-bit data bus with a one-cycle valid pulse per master. This return channel has no back-pressure, so a master must always be able to take it. The memory side has registered address, separate data out/in, a data-drive enable and active-low chip, write and output enables.

Top module: `tdm_sram_arbiter`

## Requirements
- R1: Slot ownership. A slot counter starts at slot 0 in the first cycle after reset and counts up once per cycle, wrapping after FRAME_LEN-1. FRAME_LEN is the sum of the per-master slot counts. The owners are laid out in contiguous blocks by master index: with the defaults, slots 0–64 belong to master 0, slots 65–75 to master 1, slots 76–79 to master 2 and slots 80–82 to master 3. With every master requesting, each master is granted exactly its slot count in one frame.
- R2: When the slot owner has valid high, its ready is high in that cycle. Ready is never high for a master whose valid is low.
- R3: When the owner is idle, the slot goes to the first requesting master after the last master that won a reclaimed slot, searching in increasing index order with wrap-around. After reset the search starts at master 0. Only reclaimed grants move the round-robin pointer.
- R4: A cycle with no requesting master issues no memory access: chip enable stays high in the next cycle.
- R5: One cycle after a grant, the memory pins carry the granted address with chip enable low. Write enable is low for a write and output enable is low for a read.
- R6: The data-drive enable is high only in the command cycle of a write, with the granted write word on the data out. Output enable stays high in that cycle.
- R7: Two cycles after a read grant, the data valid bit of the granted master pulses high for one cycle. The data bus then holds the memory word sampled in the command cycle. No valid bit is high at any other time.
- R8: At most one ready is high per cycle, so at most one access is made per cycle.
- R9: During reset all memory enables are inactive, the data drive is off and no data valid bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter and memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_valid | input | NUM_M | Request valid, one bit per master |
| m_ready | output | NUM_M | Request accepted this cycle; low means wait |
| m_we | input | NUM_M | 1 = write, 0 = read, per master |
| m_addr | input | NUM_M*ADDR_W | Word address, master m at bits [m*ADDR_W +: ADDR_W] |
| m_wdata | input | NUM_M*DATA_W | Write word, master m at bits [m*DATA_W +: DATA_W] |
| m_rvalid | output | NUM_M | One-cycle read data valid per master |
| m_rdata | output | DATA_W | Shared read data |
| sram_addr | output | ADDR_W | Memory address |
| sram_dout | output | DATA_W | Data toward memory |
| sram_din | input | DATA_W | Data from memory |
| sram_dq_oe | output | 1 | 1 = block drives the data lines |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume that a master keeps its request stable while ready is low. They also assume that the memory returns read data combinationally during the command cycle, and that the slot table names only existing masters. The stimulus draws new requests from a seeded generator only for masters that are not being held off. A held master repeats its exact request until the reference model predicts its grant. The memory model answers from a small array addressed by the low address bits, and the stimulus keeps addresses inside that range. Directed phases cover an all-idle stretch, a lone low-share requester that takes every slot, two requesters alternating on the processor's idle slots, and a fully loaded frame that is counted per master.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int MIDX_W = 3;              // width of a master index in the slot table
  typedef logic [MIDX_W-1:0] midx_t;
endpackage

// File: rtl/tsa_slot_sched.sv
module tsa_slot_sched
  import tsa_pkg::*;
#(
  parameter int NUM_M = 4,
  parameter int unsigned OWN_SLOTS [NUM_M] = '{65, 11, 4, 3},
  parameter int FRAME_LEN = 83,
  localparam int SLOT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic  clk,
  input  logic  rst_n,
  output midx_t owner
);
  logic [SLOT_W-1:0] slot_q;
  midx_t             tab_q [FRAME_LEN];

  function automatic midx_t init_owner(int s);
    int acc;
    acc = 0;
    init_owner = '0;
    for (int m = 0; m < NUM_M; m++) begin
      if (s >= acc && s < acc + int'(OWN_SLOTS[m])) init_owner = MIDX_W'(m);
      acc += int'(OWN_SLOTS[m]);
    end
  endfunction

  for (genvar s = 0; s < FRAME_LEN; s++) begin : g_tab
    always_ff @(posedge clk) begin
      if (!rst_n) tab_q[s] <= init_owner(s);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              slot_q <= '0;
    else if (slot_q == SLOT_W'(FRAME_LEN-1)) slot_q <= '0;
    else                                     slot_q <= slot_q + 1'b1;
  end

  assign owner = tab_q[slot_q];

  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_q) < FRAME_LEN);
  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SLOT_W'(FRAME_LEN-1)) |=> (slot_q == '0));
  p_owner_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owner) < NUM_M);
endmodule

// File: rtl/tsa_rr_pick.sv
module tsa_rr_pick
  import tsa_pkg::*;
#(
  parameter int NUM_M = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_M-1:0] req,
  input  midx_t            owner,
  output logic [NUM_M-1:0] gnt,
  output logic             gnt_any,
  output midx_t            gnt_idx
);
  midx_t last_q;
  logic  reclaim;

  always_comb begin
    gnt_idx = owner;
    gnt_any = 1'b0;
    reclaim = 1'b0;
    if (req[owner]) begin
      gnt_any = 1'b1;
    end else begin
      for (int i = 1; i <= NUM_M; i++) begin
        if (!gnt_any && req[(int'(last_q) + i) % NUM_M]) begin
          gnt_any = 1'b1;
          reclaim = 1'b1;
          gnt_idx = MIDX_W'((int'(last_q) + i) % NUM_M);
        end
      end
    end
    gnt = '0;
    for (int m = 0; m < NUM_M; m++) gnt[m] = gnt_any && (gnt_idx == MIDX_W'(m));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= MIDX_W'(NUM_M-1);
    else if (reclaim) last_q <= gnt_idx;
  end

  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_idle_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !gnt_any);
  p_rr_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reclaim |=> (last_q == $past(gnt_idx)));
endmodule

// File: rtl/tsa_sram_port.sv
module tsa_sram_port
  import tsa_pkg::*;
#(
  parameter int NUM_M  = 4,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_any,
  input  midx_t             gnt_idx,
  input  logic              sel_we,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [DATA_W-1:0] sel_wdata,
  input  logic [DATA_W-1:0] sram_din,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dout,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [NUM_M-1:0]  rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  midx_t rd_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
      sram_addr  <= '0;
      sram_dout  <= '0;
      rd_idx_q   <= '0;
      rsp_valid  <= '0;
      rsp_data   <= '0;
    end else begin
      sram_ce_n  <= !gnt_any;
      sram_we_n  <= !(gnt_any && sel_we);
      sram_oe_n  <= !(gnt_any && !sel_we);
      sram_dq_oe <= gnt_any && sel_we;
      if (gnt_any) sram_addr <= sel_addr;
      sram_dout  <= (gnt_any && sel_we) ? sel_wdata : '0;
      rd_idx_q   <= gnt_idx;
      for (int m = 0; m < NUM_M; m++)
        rsp_valid[m] <= !sram_oe_n && (rd_idx_q == MIDX_W'(m));
      if (!sram_oe_n) rsp_data <= sram_din;
    end
  end

  p_bus_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !sram_we_n && !sram_ce_n));
  p_cmd_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |=> !sram_ce_n);
  p_rd_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |=> $onehot(rsp_valid));
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_oe_n |=> (rsp_valid == '0));
endmodule

// File: rtl/tdm_sram_arbiter.sv
module tdm_sram_arbiter
  import tsa_pkg::*;
#(
  parameter int NUM_M  = 4,
  parameter int unsigned OWN_SLOTS [NUM_M] = '{65, 11, 4, 3},
  parameter int ADDR_W = 20,
  parameter int DATA_W = 36
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_M-1:0]          m_valid,
  output logic [NUM_M-1:0]          m_ready,
  input  logic [NUM_M-1:0]          m_we,
  input  logic [NUM_M*ADDR_W-1:0]   m_addr,
  input  logic [NUM_M*DATA_W-1:0]   m_wdata,
  output logic [NUM_M-1:0]          m_rvalid,
  output logic [DATA_W-1:0]         m_rdata,
  output logic [ADDR_W-1:0]         sram_addr,
  output logic [DATA_W-1:0]         sram_dout,
  input  logic [DATA_W-1:0]         sram_din,
  output logic                      sram_dq_oe,
  output logic                      sram_ce_n,
  output logic                      sram_we_n,
  output logic                      sram_oe_n
);
  function automatic int frame_total();
    frame_total = 0;
    for (int m = 0; m < NUM_M; m++) frame_total += int'(OWN_SLOTS[m]);
  endfunction
  localparam int FRAME_LEN = frame_total();

  midx_t             owner, gnt_idx;
  logic              gnt_any, sel_we;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;

  tsa_slot_sched #(.NUM_M(NUM_M), .OWN_SLOTS(OWN_SLOTS), .FRAME_LEN(FRAME_LEN)) u_sched (
    .clk(clk), .rst_n(rst_n), .owner(owner));

  tsa_rr_pick #(.NUM_M(NUM_M)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(m_valid), .owner(owner),
    .gnt(m_ready), .gnt_any(gnt_any), .gnt_idx(gnt_idx));

  always_comb begin
    sel_we    = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int m = 0; m < NUM_M; m++) begin
      if (m_ready[m]) begin
        sel_we    = m_we[m];
        sel_addr  = m_addr[m*ADDR_W +: ADDR_W];
        sel_wdata = m_wdata[m*DATA_W +: DATA_W];
      end
    end
  end

  tsa_sram_port #(.NUM_M(NUM_M), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .gnt_any(gnt_any), .gnt_idx(gnt_idx),
    .sel_we(sel_we), .sel_addr(sel_addr), .sel_wdata(sel_wdata),
    .sram_din(sram_din), .sram_addr(sram_addr), .sram_dout(sram_dout),
    .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .rsp_valid(m_rvalid), .rsp_data(m_rdata));

  p_ready_only_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ready & ~m_valid) == '0);
  p_single_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(m_ready) <= 1);
endmodule

// File: tb/sim_tdm_sram_arbiter.sv
module sim_tdm_sram_arbiter;
  localparam int NM = 4, AW = 20, DW = 36, FL = 83;
  localparam int unsigned OWN [NM] = '{65, 11, 4, 3};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NM-1:0] m_valid = '0, m_we = '0;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NM*DW-1:0] m_wdata = '0;
  logic [NM-1:0] m_ready, m_rvalid;
  logic [DW-1:0] m_rdata, sram_dout, sram_din;
  logic [AW-1:0] sram_addr;
  logic sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n;

  tdm_sram_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .sram_addr(sram_addr), .sram_dout(sram_dout), .sram_din(sram_din),
    .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n));

  // memory model: 64 words, combinational read, clocked write
  logic [DW-1:0] mem [64];
  initial for (int i = 0; i < 64; i++) mem[i] = '0;
  always @(posedge clk) if (!sram_ce_n && !sram_we_n && sram_dq_oe) mem[sram_addr[5:0]] <= sram_dout;
  assign sram_din = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr[5:0]] : '0;

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int owner_of(int s);
    int acc = 0;
    owner_of = 0;
    for (int m = 0; m < NM; m++) begin
      if (s >= acc && s < acc + int'(OWN[m])) owner_of = m;
      acc += int'(OWN[m]);
    end
  endfunction

  // reference state
  int cnt = 0, last_rc = NM - 1;
  logic [NM-1:0] hold = '0;
  logic [DW-1:0] shadow [64];
  bit p1_any = 0, p1_we = 0; logic [AW-1:0] p1_addr = '0; logic [DW-1:0] p1_wd = '0, p1_rd = '0; int p1_idx = 0;
  bit p2_rd = 0; int p2_idx = 0; logic [DW-1:0] p2_data = '0;
  int gcount [NM];

  // mode: 0 random, 1 idle, 2 only master 3, 3 masters 1 and 2, 4 all
  task automatic cycle(int mode);
    int own, g;
    logic [NM-1:0] ev;
    bit v;
    for (int m = 0; m < NM; m++) begin
      if (!hold[m]) begin
        case (mode)
          0: v = ($urandom_range(0, 1) == 1);
          1: v = 0;
          2: v = (m == 3);
          3: v = (m == 1 || m == 2);
          default: v = 1;
        endcase
        m_valid[m] = v;
        m_we[m] = ($urandom_range(0, 1) == 1);
        m_addr[m*AW +: AW] = AW'($urandom_range(0, 63));
        m_wdata[m*DW +: DW] = {$urandom, $urandom};
      end
    end
    #1;
    own = owner_of(cnt);
    g = -1;
    if (m_valid[own]) g = own;
    else begin
      for (int i = 1; i <= NM; i++)
        if (g < 0 && m_valid[(last_rc + i) % NM]) g = (last_rc + i) % NM;
      if (g >= 0) last_rc = g;
    end
    ev = (g >= 0) ? NM'(1 << g) : '0;
    chk(m_ready == ev, (g == own) ? "R2 ready" : "R3 ready", 64'(m_ready), 64'(ev));
    // command from previous grant (R4, R5, R6)
    chk(sram_ce_n == !p1_any, p1_any ? "R5 ce_n" : "R4 ce_n idle", 64'(sram_ce_n), 64'(!p1_any));
    if (p1_any) begin
      chk(sram_addr == p1_addr, "R5 addr", 64'(sram_addr), 64'(p1_addr));
      chk(sram_we_n == !p1_we, "R5 we_n", 64'(sram_we_n), 64'(!p1_we));
      chk(sram_oe_n == p1_we, "R6 oe_n", 64'(sram_oe_n), 64'(p1_we));
    end
    chk(sram_dq_oe == (p1_any && p1_we), "R6 dq_oe", 64'(sram_dq_oe), 64'(p1_any && p1_we));
    if (p1_any && p1_we) chk(sram_dout == p1_wd, "R6 dout", 64'(sram_dout), 64'(p1_wd));
    // read return from grant two cycles ago (R7)
    chk(m_rvalid == (p2_rd ? NM'(1 << p2_idx) : '0), "R7 rvalid", 64'(m_rvalid),
        64'(p2_rd ? NM'(1 << p2_idx) : '0));
    if (p2_rd) chk(m_rdata == p2_data, "R7 rdata", 64'(m_rdata), 64'(p2_data));
    // shift reference pipeline
    p2_rd = p1_any && !p1_we; p2_idx = p1_idx; p2_data = p1_rd;
    p1_any = (g >= 0);
    if (g >= 0) begin
      gcount[g]++;
      p1_idx = g;
      p1_we = m_we[g];
      p1_addr = m_addr[g*AW +: AW];
      p1_wd = m_wdata[g*DW +: DW];
      p1_rd = shadow[p1_addr[5:0]];
      if (p1_we) shadow[p1_addr[5:0]] = p1_wd;
    end else p1_we = 0;
    hold = m_valid & ~ev;
    cnt = (cnt + 1) % FL;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    for (int m = 0; m < NM; m++) gcount[m] = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(sram_ce_n == 1'b1, "R9 ce_n", 64'(sram_ce_n), 64'd1);
    chk(sram_we_n == 1'b1, "R9 we_n", 64'(sram_we_n), 64'd1);
    chk(sram_oe_n == 1'b1, "R9 oe_n", 64'(sram_oe_n), 64'd1);
    chk(sram_dq_oe == 1'b0, "R9 dq_oe", 64'(sram_dq_oe), 64'd0);
    chk(m_rvalid == '0, "R9 rvalid", 64'(m_rvalid), 64'd0);
    rst_n = 1'b1;
    repeat (400) cycle(0);
    repeat (12) cycle(1);   // R4 idle stretch
    repeat (120) cycle(2);  // R3 lone slow requester
    repeat (120) cycle(3);  // R3 alternation in idle owner slots
    while (cnt != 0) cycle(0);
    for (int m = 0; m < NM; m++) gcount[m] = 0;
    repeat (FL) cycle(4);   // R1 saturated frame
    for (int m = 0; m < NM; m++)
      chk(gcount[m] == int'(OWN[m]), "R1 slots per frame", 64'(gcount[m]), 64'(OWN[m]));
    repeat (400) cycle(0);
    repeat (4) cycle(1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule